// File: doc/BRIEF.md
# Stack and Interrupt Entry/Return Sequencer

This block is a multi-cycle controller that carries out word-wide stack and control-transfer sequences through a single 16-bit memory port. It runs six kinds of sequence: push an operand, pop a word, call a target, return, enter a software interrupt, and return from an interrupt. It holds its own copies of five registers: the program offset, the code segment, the stack segment, the stack pointer and the status word. Each sequence reads and updates those copies.

A command is accepted when the block is idle. The command carries an opcode, an 8-bit vector number, a target offset and an operand word. The block then issues its memory accesses one at a time. Each access waits for a ready response. Stack accesses go to the linear address segment×16 + pointer, kept to 20 bits. Vector-table reads use segment zero. When the last access completes, the updated registers appear on the outputs together with a one-cycle done pulse.

Interrupt entry saves three words on the stack and then fetches the new program offset and code segment from the vector table. Interrupt return restores the same three words in the reverse order. Instruction fetch and decode are handled elsewhere.

Top module: `stk_irq_seq`

## Requirements
- R1: During and after reset, mem_req, busy and done are 0, and the register outputs equal their reset parameters.
- R2: Opcode 1 (push) first lowers the stack pointer by 2 and then writes cmd_wdata to address stack segment×16 + new pointer (20 bits).
- R3: Opcode 2 (pop) reads the word at stack segment×16 + pointer into pop_data and then raises the pointer by 2.
- R4: Opcode 3 (call) pushes the program offset as in R2 and then loads cmd_target into it. Opcode 4 (return) pops a word into the program offset as in R3.
- R5: Opcode 5 (interrupt entry) writes the status word, then the code segment, then the program offset to successive pushed stack slots. It then reads the word at byte address vector×4 into the program offset and the word at vector×4+2 into the code segment, using segment zero.
- R6: Interrupt entry clears status bit 9 (interrupt enable) and bit 8 (trap) only after the status word has been written, so the saved copy holds the old values.
- R7: Opcode 6 (interrupt return) pops the program offset, then the code segment, then the status word, and all 16 status bits take the popped value. The pointer rises by 6.
- R8: Each access keeps mem_req, mem_addr, mem_we and mem_wdata steady until mem_ready is sampled high, and only one access is in flight at a time.
- R9: done is high for exactly one cycle: the cycle after the rising edge at which the last access saw mem_ready. The register outputs already hold their final values in that cycle.
- R10: A command presented while busy is high is ignored. It causes no access, no register change and no extra done pulse.
- R11: Opcodes 0 and 7 cause no access, no done pulse and no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_op | input | 3 | Opcode (see requirements) |
| cmd_vec | input | 8 | Interrupt vector number |
| cmd_target | input | 16 | Call target offset |
| cmd_wdata | input | 16 | Operand word for push |
| mem_req | output | 1 | Memory access request |
| mem_addr | output | 20 | Byte address of the word accessed |
| mem_we | output | 1 | 1 for a write access |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes at this edge |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_o | output | 16 | Program offset |
| cseg_o | output | 16 | Code segment |
| sseg_o | output | 16 | Stack segment |
| sptr_o | output | 16 | Stack pointer |
| stat_o | output | 16 | Status word |
| pop_data | output | 16 | Last word popped by opcode 2 |

## Verification
A command strobed for one cycle is taken at the next rising edge. The first request appears in the cycle after that edge. Each access ends at the first edge where ready is high. Register results and done appear in the cycle that follows the last such edge, and done falls one cycle later. The memory model in the bench answers on falling edges with latencies of zero to three cycles. It logs every access so that order, addresses and data can be compared with a list computed from the requirements. The bench reads the outputs on the falling edge where done is first seen and checks that done is low on the next falling edge. Ignored commands are checked by counting logged accesses and done pulses over a quiet window that follows them.

// File: rtl/stk_seq_pkg.sv
package stk_seq_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_PUSH = 3'd1,
    OP_POP  = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4,
    OP_INT  = 3'd5,
    OP_IRET = 3'd6,
    OP_RSVD = 3'd7
  } seq_op_e;

  typedef enum logic [1:0] {
    AK_STK_WR = 2'd0,
    AK_STK_RD = 2'd1,
    AK_VEC_RD = 2'd2
  } acc_kind_e;

  typedef enum logic [1:0] {
    SRC_DATA = 2'd0,
    SRC_PC   = 2'd1,
    SRC_CSEG = 2'd2,
    SRC_STAT = 2'd3
  } wsrc_e;

  typedef enum logic [1:0] {
    DST_DATA = 2'd0,
    DST_PC   = 2'd1,
    DST_CSEG = 2'd2,
    DST_STAT = 2'd3
  } rdst_e;

  // one memory access of a sequence
  typedef struct packed {
    acc_kind_e kind;
    wsrc_e     src;
    rdst_e     dst;
    logic      vec_hi;    // second word of a vector entry
    logic      last;      // final access of the sequence
    logic      load_tgt;  // program offset takes the call target
    logic      mask_int;  // clear enable and trap after this access
  } step_t;

  localparam int MAX_STEPS = 5;

endpackage

// File: rtl/stk_step_rom.sv
module stk_step_rom
  import stk_seq_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  seq_op_e           op,
  input  logic [STEP_W-1:0] step,
  output step_t             desc
);

  always_comb begin
    desc = '0;
    unique case (op)
      OP_PUSH: begin
        desc.kind = AK_STK_WR; desc.src = SRC_DATA; desc.last = 1'b1;
      end
      OP_POP: begin
        desc.kind = AK_STK_RD; desc.dst = DST_DATA; desc.last = 1'b1;
      end
      OP_CALL: begin
        desc.kind = AK_STK_WR; desc.src = SRC_PC;
        desc.last = 1'b1; desc.load_tgt = 1'b1;
      end
      OP_RET: begin
        desc.kind = AK_STK_RD; desc.dst = DST_PC; desc.last = 1'b1;
      end
      OP_INT: begin
        case (step)
          STEP_W'(0): begin
            desc.kind = AK_STK_WR; desc.src = SRC_STAT; desc.mask_int = 1'b1;
          end
          STEP_W'(1): begin desc.kind = AK_STK_WR; desc.src = SRC_CSEG; end
          STEP_W'(2): begin desc.kind = AK_STK_WR; desc.src = SRC_PC; end
          STEP_W'(3): begin desc.kind = AK_VEC_RD; desc.dst = DST_PC; end
          default: begin
            desc.kind = AK_VEC_RD; desc.dst = DST_CSEG;
            desc.vec_hi = 1'b1; desc.last = 1'b1;
          end
        endcase
      end
      OP_IRET: begin
        case (step)
          STEP_W'(0): begin desc.kind = AK_STK_RD; desc.dst = DST_PC; end
          STEP_W'(1): begin desc.kind = AK_STK_RD; desc.dst = DST_CSEG; end
          default: begin
            desc.kind = AK_STK_RD; desc.dst = DST_STAT; desc.last = 1'b1;
          end
        endcase
      end
      default: desc.last = 1'b1;
    endcase
  end

endmodule

// File: rtl/stk_addr_gen.sv
module stk_addr_gen
  import stk_seq_pkg::*;
#(
  parameter int DW        = 16,
  parameter int AW        = 20,
  parameter int SEG_SHIFT = 4,
  parameter int VEC_W     = 8
) (
  input  acc_kind_e        kind,
  input  logic [DW-1:0]    seg,
  input  logic [DW-1:0]    ptr,
  input  logic [VEC_W-1:0] vec,
  input  logic             vec_hi,
  output logic [AW-1:0]    addr
);

  localparam int SUMW       = DW + SEG_SHIFT;
  localparam int WORD_BYTES = DW / 8;

  logic [DW-1:0]   ptr_eff;
  logic [SUMW-1:0] lin;

  always_comb begin
    ptr_eff = (kind == AK_STK_WR) ? ptr - DW'(WORD_BYTES) : ptr;
    lin     = {seg, {SEG_SHIFT{1'b0}}} + SUMW'(ptr_eff);
    if (kind == AK_VEC_RD) addr = AW'({vec, vec_hi, 1'b0});
    else                   addr = AW'(lin);
  end

endmodule

// File: rtl/stk_irq_seq.sv
module stk_irq_seq
  import stk_seq_pkg::*;
#(
  parameter int          DW        = 16,
  parameter int          AW        = 20,
  parameter int          SEG_SHIFT = 4,
  parameter int          VEC_W     = 8,
  parameter int          IE_BIT    = 9,
  parameter int          TRAP_BIT  = 8,
  parameter logic [15:0] RST_PC    = 16'h0000,
  parameter logic [15:0] RST_CSEG  = 16'h0000,
  parameter logic [15:0] RST_SSEG  = 16'h0020,
  parameter logic [15:0] RST_SPTR  = 16'h0100,
  parameter logic [15:0] RST_STAT  = 16'h0302
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [VEC_W-1:0] cmd_vec,
  input  logic [DW-1:0]    cmd_target,
  input  logic [DW-1:0]    cmd_wdata,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_we,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_ready,
  output logic             busy,
  output logic             done,
  output logic [DW-1:0]    pc_o,
  output logic [DW-1:0]    cseg_o,
  output logic [DW-1:0]    sseg_o,
  output logic [DW-1:0]    sptr_o,
  output logic [DW-1:0]    stat_o,
  output logic [DW-1:0]    pop_data
);

  localparam int STEP_W     = $clog2(MAX_STEPS);
  localparam int WORD_BYTES = DW / 8;

  logic              busy_q, done_q;
  seq_op_e           op_q;
  logic [STEP_W-1:0] step_q;
  logic [VEC_W-1:0]  vec_q;
  logic [DW-1:0]     tgt_q, opnd_q;
  logic [DW-1:0]     pc_q, cseg_q, sseg_q, sptr_q, stat_q, popd_q;
  step_t             desc;
  seq_op_e           op_in;
  logic              op_ok;

  assign op_in = seq_op_e'(cmd_op);
  assign op_ok = (op_in != OP_NONE) && (op_in != OP_RSVD);

  stk_step_rom #(.STEP_W(STEP_W)) u_rom (
    .op   (op_q),
    .step (step_q),
    .desc (desc)
  );

  stk_addr_gen #(.DW(DW), .AW(AW), .SEG_SHIFT(SEG_SHIFT), .VEC_W(VEC_W)) u_agen (
    .kind   (desc.kind),
    .seg    (sseg_q),
    .ptr    (sptr_q),
    .vec    (vec_q),
    .vec_hi (desc.vec_hi),
    .addr   (mem_addr)
  );

  always_comb begin
    unique case (desc.src)
      SRC_PC:   mem_wdata = pc_q;
      SRC_CSEG: mem_wdata = cseg_q;
      SRC_STAT: mem_wdata = stat_q;
      default:  mem_wdata = opnd_q;
    endcase
  end

  assign mem_req = busy_q;
  assign mem_we  = busy_q && (desc.kind == AK_STK_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      op_q   <= OP_NONE;
      step_q <= '0;
      vec_q  <= '0;
      tgt_q  <= '0;
      opnd_q <= '0;
      pc_q   <= RST_PC;
      cseg_q <= RST_CSEG;
      sseg_q <= RST_SSEG;
      sptr_q <= RST_SPTR;
      stat_q <= RST_STAT;
      popd_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (cmd_valid && op_ok) begin
          busy_q <= 1'b1;
          op_q   <= op_in;
          step_q <= '0;
          vec_q  <= cmd_vec;
          tgt_q  <= cmd_target;
          opnd_q <= cmd_wdata;
        end
      end else if (mem_ready) begin
        if (desc.kind == AK_STK_WR)      sptr_q <= sptr_q - DW'(WORD_BYTES);
        else if (desc.kind == AK_STK_RD) sptr_q <= sptr_q + DW'(WORD_BYTES);
        if (desc.kind != AK_STK_WR) begin
          unique case (desc.dst)
            DST_PC:   pc_q   <= mem_rdata;
            DST_CSEG: cseg_q <= mem_rdata;
            DST_STAT: stat_q <= mem_rdata;
            default:  popd_q <= mem_rdata;
          endcase
        end
        if (desc.mask_int) begin
          stat_q[IE_BIT]   <= 1'b0;
          stat_q[TRAP_BIT] <= 1'b0;
        end
        if (desc.load_tgt) pc_q <= tgt_q;
        if (desc.last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          step_q <= step_q + STEP_W'(1);
        end
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign pc_o     = pc_q;
  assign cseg_o   = cseg_q;
  assign sseg_o   = sseg_q;
  assign sptr_o   = sptr_q;
  assign stat_o   = stat_q;
  assign pop_data = popd_q;

  // request and its fields stay put while ready is low
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // completion strobe never lasts two cycles
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // the captured opcode cannot be replaced mid-sequence
  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> $stable(op_q));

  // a completed interrupt entry leaves enable and trap low
  assert_int_mask_R6: assert property (@(posedge clk) disable iff (rst)
    done && op_q == OP_INT |-> !stat_o[IE_BIT] && !stat_o[TRAP_BIT]);

  // vector table accesses are reads
  assert_vec_read_R5: assert property (@(posedge clk) disable iff (rst)
    mem_req && desc.kind == AK_VEC_RD |-> !mem_we);

  // a completed write moves the pointer down one word
  assert_push_dec_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we && mem_ready |=> sptr_o == $past(sptr_o) - DW'(WORD_BYTES));

endmodule

// File: tb/tb_stk_irq_seq.sv
module tb_stk_irq_seq;

  localparam logic [15:0] P_PC   = 16'h1234;
  localparam logic [15:0] P_CSEG = 16'h0F00;
  localparam logic [15:0] P_SSEG = 16'h0020;
  localparam logic [15:0] P_SPTR = 16'h0100;
  localparam logic [15:0] P_STAT = 16'h0302;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [7:0]  cmd_vec = 8'd0;
  logic [15:0] cmd_target = 16'd0;
  logic [15:0] cmd_wdata = 16'd0;
  logic        mem_req, mem_we, busy, done;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = 16'd0;
  logic        mem_ready = 1'b0;
  logic [15:0] pc_o, cseg_o, sseg_o, sptr_o, stat_o, pop_data;

  always #2 clk = ~clk;

  stk_irq_seq #(.RST_PC(P_PC), .RST_CSEG(P_CSEG), .RST_SSEG(P_SSEG),
                .RST_SPTR(P_SPTR), .RST_STAT(P_STAT)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_vec(cmd_vec), .cmd_target(cmd_target), .cmd_wdata(cmd_wdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .busy(busy), .done(done), .pc_o(pc_o), .cseg_o(cseg_o),
    .sseg_o(sseg_o), .sptr_o(sptr_o), .stat_o(stat_o), .pop_data(pop_data));

  int checks = 0;
  int errors = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model with programmable latency and access log
  logic [15:0] bmem [0:2047];
  int          lat = 0;
  int          wcnt = 0;
  logic [19:0] lg_addr [0:15];
  logic        lg_we   [0:15];
  logic [15:0] lg_wd   [0:15];
  int          lg_n = 0;
  logic        prev_wait = 1'b0;
  logic [19:0] prev_addr = '0;
  logic [15:0] prev_wd = '0;
  logic        prev_we = 1'b0;

  initial for (int i = 0; i < 2048; i++) bmem[i] = 16'(i * 16'h0107 + 16'h3C5A);

  always @(negedge clk) begin
    if (rst) begin
      mem_ready = 1'b0; wcnt = 0; prev_wait = 1'b0;
    end else begin
      if (prev_wait) begin
        check("R8 hold", {11'd0, mem_req, mem_we, mem_addr[18:0]},
              {11'd0, 1'b1, prev_we, prev_addr[18:0]});
        if (prev_we) check("R8 hold data", {16'd0, mem_wdata}, {16'd0, prev_wd});
      end
      if (mem_ready) wcnt = 0;
      mem_ready = 1'b0;
      if (mem_req) begin
        if (wcnt >= lat) begin
          mem_ready = 1'b1;
          if (lg_n < 16) begin
            lg_addr[lg_n] = mem_addr; lg_we[lg_n] = mem_we;
            lg_wd[lg_n] = mem_we ? mem_wdata : 16'd0;
          end
          lg_n++;
          if (mem_we) bmem[mem_addr[11:1]] = mem_wdata;
          else        mem_rdata = bmem[mem_addr[11:1]];
        end else begin
          wcnt++;
        end
      end
      prev_wait = mem_req && !mem_ready;
      prev_addr = mem_addr; prev_we = mem_we; prev_wd = mem_wdata;
    end
  end

  // reference model
  logic [15:0] m_pc = P_PC, m_cs = P_CSEG, m_ss = P_SSEG, m_sp = P_SPTR, m_fl = P_STAT, m_pd = 16'd0;
  logic [19:0] ex_addr [0:15];
  logic        ex_we   [0:15];
  logic [15:0] ex_wd   [0:15];
  int          ex_n = 0;

  function automatic logic [19:0] lin(input logic [15:0] seg, input logic [15:0] off);
    return 20'({seg, 4'h0} + {4'h0, off});
  endfunction

  task automatic ex_acc(input logic [19:0] a, input logic w, input logic [15:0] d);
    ex_addr[ex_n] = a; ex_we[ex_n] = w; ex_wd[ex_n] = w ? d : 16'd0; ex_n++;
  endtask

  task automatic ex_push(input logic [15:0] d);
    m_sp = m_sp - 16'd2; ex_acc(lin(m_ss, m_sp), 1'b1, d);
  endtask

  task automatic ex_pop(output logic [15:0] d);
    ex_acc(lin(m_ss, m_sp), 1'b0, 16'd0);
    d = bmem[lin(m_ss, m_sp) >> 1];
    m_sp = m_sp + 16'd2;
  endtask

  task automatic model(input logic [2:0] op, input logic [7:0] v,
                       input logic [15:0] tgt, input logic [15:0] dat);
    logic [15:0] t;
    ex_n = 0;
    case (op)
      3'd1: ex_push(dat);
      3'd2: begin ex_pop(t); m_pd = t; end
      3'd3: begin ex_push(m_pc); m_pc = tgt; end
      3'd4: begin ex_pop(t); m_pc = t; end
      3'd5: begin
        ex_push(m_fl); ex_push(m_cs); ex_push(m_pc);
        ex_acc({10'd0, v, 2'b00}, 1'b0, 16'd0);
        ex_acc({10'd0, v, 2'b10}, 1'b0, 16'd0);
        m_pc = bmem[{v, 1'b0}];
        m_cs = bmem[{v, 1'b1}];
        m_fl = m_fl & ~16'h0300;
      end
      3'd6: begin
        ex_pop(t); m_pc = t;
        ex_pop(t); m_cs = t;
        ex_pop(t); m_fl = t;
      end
      default: ;
    endcase
  endtask

  task automatic check_regs(input string tag);
    check({tag, " pc"},   {16'd0, pc_o},   {16'd0, m_pc});
    check({tag, " cseg"}, {16'd0, cseg_o}, {16'd0, m_cs});
    check({tag, " sseg"}, {16'd0, sseg_o}, {16'd0, m_ss});
    check({tag, " sptr"}, {16'd0, sptr_o}, {16'd0, m_sp});
    check({tag, " stat"}, {16'd0, stat_o}, {16'd0, m_fl});
  endtask

  task automatic run(input logic [2:0] op, input logic [7:0] v, input logic [15:0] tgt,
                     input logic [15:0] dat, input string tag, input bit poke);
    int t;
    model(op, v, tgt, dat);
    @(negedge clk);
    lg_n = 0;
    cmd_valid = 1'b1; cmd_op = op; cmd_vec = v; cmd_target = tgt; cmd_wdata = dat;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (poke) begin
      // R10: a command while busy must be dropped
      @(negedge clk);
      check("R10 busy during sequence", {31'd0, busy}, 32'd1);
      cmd_valid = 1'b1; cmd_op = 3'd1; cmd_wdata = 16'hDEAD;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    t = 0;
    while (!done && t < 300) begin @(negedge clk); t++; end
    check({tag, " R9 done seen"}, {31'd0, done}, 32'd1);
    check({tag, " access count"}, lg_n, ex_n);
    for (int i = 0; i < ex_n && i < lg_n && i < 16; i++) begin
      check({tag, " addr"}, {12'd0, lg_addr[i]}, {12'd0, ex_addr[i]});
      check({tag, " dir"},  {31'd0, lg_we[i]},  {31'd0, ex_we[i]});
      check({tag, " wdata"}, {16'd0, lg_wd[i]}, {16'd0, ex_wd[i]});
    end
    check_regs({tag, " R9 regs at done"});
    if (op == 3'd2) check({tag, " pop_data"}, {16'd0, pop_data}, {16'd0, m_pd});
    @(negedge clk);
    check({tag, " R9 done one cycle"}, {31'd0, done}, 32'd0);
    if (poke) begin
      t = 0;
      for (int i = 0; i < 6; i++) begin @(negedge clk); if (done) t++; end
      check("R10 no extra access", lg_n, ex_n);
      check("R10 no extra done", t, 0);
      check_regs("R10 regs unchanged");
    end
  endtask

  task automatic run_null(input logic [2:0] op);
    int d;
    @(negedge clk);
    lg_n = 0;
    cmd_valid = 1'b1; cmd_op = op; cmd_wdata = 16'hBEEF;
    @(negedge clk);
    cmd_valid = 1'b0;
    d = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (done || busy) d++; end
    check("R11 no access", lg_n, 0);
    check("R11 no done/busy", d, 0);
    check_regs("R11 regs");
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] w;
    repeat (3) @(negedge clk);
    check("R1 req in reset", {31'd0, mem_req}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 req", {31'd0, mem_req}, 32'd0);
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 done", {31'd0, done}, 32'd0);
    check_regs("R1 reset");

    run_null(3'd0);
    run_null(3'd7);

    // R2 pushes at every latency, then R3 pops back in reverse
    for (int i = 0; i < 8; i++) begin
      lat = i % 4;
      run(3'd1, 8'd0, 16'd0, 16'(16'h1111 * (i + 1) ^ 16'h5A00), "R2 push", 1'b0);
    end
    for (int i = 0; i < 8; i++) begin
      lat = (i + 1) % 4;
      run(3'd2, 8'd0, 16'd0, 16'd0, "R3 pop", 1'b0);
      check("R3 lifo order", {16'd0, pop_data}, {16'd0, 16'(16'h1111 * (8 - i) ^ 16'h5A00)});
    end

    // R4 nested calls then returns
    for (int i = 0; i < 4; i++) begin
      lat = i;
      run(3'd3, 8'd0, 16'(16'h4000 + i * 16'h0123), 16'd0, "R4 call", 1'b0);
    end
    for (int i = 0; i < 4; i++) begin
      lat = 3 - i;
      run(3'd4, 8'd0, 16'd0, 16'd0, "R4 ret", 1'b0);
    end
    check("R4 pc restored", {16'd0, pc_o}, {16'd0, P_PC});

    // R5/R6/R7 entry and return for a sweep of vectors
    for (int v = 0; v < 64; v++) begin
      lat = v % 4;
      w = m_fl;
      run(3'd5, 8'(v), 16'd0, 16'd0, "R5 int entry", 1'b0);
      check("R6 saved status old", {16'd0, bmem[(lin(m_ss, m_sp) >> 1) + 2]}, {16'd0, w});
      check("R6 enable/trap cleared", {30'd0, stat_o[9], stat_o[8]}, 32'd0);
      run(3'd6, 8'd0, 16'd0, 16'd0, "R7 int return", 1'b0);
      check("R7 status restored", {16'd0, stat_o}, {16'd0, w});
    end

    // R7 with hand-built frames: every status bit replaced
    for (int i = 0; i < 4; i++) begin
      lat = i;
      run(3'd1, 8'd0, 16'd0, 16'(16'hFFFF >> (i * 4)) ^ 16'h0F0F, "R7 frame stat", 1'b0);
      run(3'd1, 8'd0, 16'd0, 16'(16'h2000 + i), "R7 frame cs", 1'b0);
      run(3'd1, 8'd0, 16'd0, 16'(16'h7000 + i), "R7 frame pc", 1'b0);
      run(3'd6, 8'd0, 16'd0, 16'd0, "R7 iret frame", 1'b0);
    end

    // R10 command during a long sequence
    lat = 3;
    run(3'd5, 8'd17, 16'd0, 16'd0, "R10 int with poke", 1'b1);
    run(3'd6, 8'd0, 16'd0, 16'd0, "R10 iret after poke", 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule